// File: doc/BRIEF.md
# Receive Message Queue with Selectable Depth and Fill Interrupt

This block holds the messages that a bus controller's receive path has accepted until the CPU reads them out. Each message is one opaque word. The words are kept in first-in, first-out order. The usable depth is chosen at run time from a three-bit code: no storage, 4, 8 or 16 entries. The block reports empty, full and the current fill count. A sticky flag records a message that was lost because the queue was full.

A 16-bit control word configures the block. It is written through a simple write strobe and can always be read back. Software can ask for an interrupt pulse on every stored message. It can instead ask for a pulse when the fill count reaches a programmable number of eighths of the depth.

A global mode input decides which control fields a write may change. The depth and the interrupt source can only be altered while the system is held in its reset mode. The queue itself can only be switched on or off in the operating or test modes. The interrupt enable cannot be altered while the queue is switched on.

Top module: `msg_rx_queue`

## Requirements
- R1: Control bit 0 (`on`) switches the queue on. While it reads 0, the stored contents are discarded and the queue reports empty with a zero fill count. This takes effect from the second clock edge after the write that clears it. Writing 1 again in operating mode (gmode 01) or test mode (gmode 10) switches the queue back on.
- R2: Control bit 1 (`irq_on`) allows interrupt pulses. A write changes this bit only if bit 0 held 0 when the write arrived. While bit 1 is 0, no pulse is produced.
- R3: Control bits 10:8 select the depth: 000 means no storage, 001 means 4 entries, 010 means 8 and 011 means 16. A write carrying a code of 100 to 111 leaves the field at its previous value.
- R4: Bits 10:8 and bit 12 change only on writes made while gmode is 00 (reset mode). Bit 0 changes only on writes made while gmode is 01 or 10. Bits 15:13 change on any write. gmode 11 permits no change to bits 0, 10:8 or 12. In every mode, a write still updates each field whose own rule permits it.
- R5: Stored words come out of the pop port in push order. A pop updates `pop_data` at the clock edge that accepts it. `fill_o`, `empty_o` and `full_o` update at the same edge as the push or pop. `full_o` is 1 when the fill count equals the selected depth.
- R6: When bit 12 is 1 and interrupts are allowed, `irq_o` is high for the one cycle after each accepted push.
- R7: When bit 12 is 0 and interrupts are allowed, `irq_o` pulses for one cycle after an accepted push that leaves the fill count equal to max(1, ceil(depth*(T+1)/8)), where T is the value in bits 15:13. T=0 means one eighth full and T=7 means completely full.
- R8: A push arriving while the queue is full is dropped, even if a pop arrives in the same cycle. It leaves the fill count unchanged and sets `ovf_o`. `ovf_o` stays set until bit 0 is cleared.
- R9: A pop while the queue is empty changes nothing. `pop_data` keeps the last word it delivered.
- R10: While bit 0 is 0 or bits 10:8 are 000, pushes are discarded, the fill count stays 0 and no interrupt is produced.
- R11: After reset the control word reads 0x0000, the queue is empty and `pop_data`, `ovf_o` and `irq_o` are 0. Bits 7:2 and bit 11 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gmode | input | 2 | Global mode: 00 reset, 01 operating, 10 test, 11 none |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Current control word |
| push_i | input | 1 | Store one message from the receive path |
| push_data | input | MSG_W | Message word to store |
| pop_i | input | 1 | Remove the oldest message |
| pop_data | output | MSG_W | Last popped message word |
| empty_o | output | 1 | No unread message |
| full_o | output | 1 | Fill count equals the selected depth |
| fill_o | output | CNT_W | Number of stored messages |
| ovf_o | output | 1 | Sticky: a message was dropped because the queue was full |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check the following rules on every cycle:
- each control field changes only in the modes that permit it;
- a switched-off queue empties and clears its overflow flag;
- a full queue refuses a push without a pop;
- the empty flag, the full flag and the fill count stay consistent with each other;
- every interrupt pulse follows an accepted push while interrupts are allowed.

Some behaviour can only be shown by the bench's directed scenarios against its own reference queue:
- first-in, first-out order at each of the three depths;
- the exact fill count at which each of the eight threshold codes fires;
- the per-message pulse train;
- which value a dropped write leaves in each field.

// File: rtl/msg_rx_queue_pkg.sv
package msg_rx_queue_pkg;

  typedef enum logic [1:0] {
    GM_RESET = 2'b00,
    GM_OPER  = 2'b01,
    GM_TEST  = 2'b10,
    GM_NONE  = 2'b11
  } gmode_e;

  // Control word fields, listed from the most significant bit down.
  typedef struct packed {
    logic [2:0] thr;     // 15:13 fill threshold in eighths
    logic       src;     // 12 1 = pulse on every message
    logic [2:0] depth;   // 10:8 depth code
    logic       irq_on;  // 1
    logic       on;      // 0
  } ctrl_t;

  localparam logic [2:0] DEPTH_MAX_CODE = 3'd3;

endpackage

// File: rtl/mrq_ctrl_reg.sv
module mrq_ctrl_reg
  import msg_rx_queue_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  gmode,
  input  logic        we,
  input  logic [2:0]  w_thr,
  input  logic        w_src,
  input  logic [2:0]  w_depth,
  input  logic        w_irq_on,
  input  logic        w_on,
  output ctrl_t       ctrl,
  output logic        depth_chg
);

  gmode_e gm;
  logic   cfg_ok;
  logic   on_ok;
  logic   depth_legal;

  assign gm          = gmode_e'(gmode);
  assign cfg_ok      = (gm == GM_RESET);
  assign on_ok       = (gm == GM_OPER) || (gm == GM_TEST);
  assign depth_legal = (w_depth <= DEPTH_MAX_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      depth_chg <= 1'b0;
    end else begin
      depth_chg <= 1'b0;
      if (we) begin
        ctrl.thr <= w_thr;
        if (cfg_ok) begin
          ctrl.src <= w_src;
          if (depth_legal) begin
            ctrl.depth <= w_depth;
            depth_chg  <= (w_depth != ctrl.depth);
          end
        end
        if (on_ok) begin
          ctrl.on <= w_on;
        end
        if (!ctrl.on) begin
          ctrl.irq_on <= w_irq_on;
        end
      end
    end
  end

endmodule

// File: rtl/mrq_store.sv
module mrq_store #(
  parameter int MSG_W     = 32,
  parameter int MAX_DEPTH = 16,
  parameter int PTR_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [CNT_W-1:0] depth_n,
  input  logic             push,
  input  logic [MSG_W-1:0] wdat,
  input  logic             pop,
  output logic [MSG_W-1:0] rdat,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             push_ok,
  output logic             empty,
  output logic             full,
  output logic             ovf
);

  logic [MSG_W-1:0] mem [MAX_DEPTH];
  logic [PTR_W-1:0] wp, rp, mask;
  logic             live;
  logic             pop_ok;

  assign mask = depth_n[PTR_W-1:0] - PTR_W'(1);

  always_comb begin
    live    = !flush && (depth_n != '0);
    push_ok = push && live && (cnt != depth_n);
    pop_ok  = pop && live && (cnt != '0);
    cnt_nxt = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  // Storage array: no reset, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wp] <= wdat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdat <= '0;
    end else if (pop_ok) begin
      rdat <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) begin
        wp <= (wp + PTR_W'(1)) & mask;
      end
      if (pop_ok) begin
        rp <= (rp + PTR_W'(1)) & mask;
      end
      cnt   <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      full  <= (cnt_nxt == depth_n) && (depth_n != '0);
      if (push && !push_ok && live) begin
        ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mrq_irq.sv
module mrq_irq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_on,
  input  logic             src,
  input  logic [2:0]       thr,
  input  logic [CNT_W-1:0] depth_n,
  input  logic             push_ok,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             irq
);

  localparam int PW = CNT_W + 4;

  logic [PW-1:0] prod;
  logic [PW-1:0] lvl;
  logic          hit;

  always_comb begin
    prod = PW'(depth_n) * PW'({1'b0, thr} + 4'd1);
    lvl  = (prod + PW'(7)) >> 3;
    if (lvl == '0) begin
      lvl = PW'(1);
    end
    hit = src || (PW'(cnt_nxt) == lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_on && push_ok && hit;
    end
  end

endmodule

// File: rtl/msg_rx_queue.sv
module msg_rx_queue
  import msg_rx_queue_pkg::*;
#(
  parameter int  MSG_W      = 32,
  parameter int  BASE_DEPTH = 4,
  localparam int MAX_DEPTH  = BASE_DEPTH * 4,
  localparam int PTR_W      = $clog2(MAX_DEPTH),
  localparam int CNT_W      = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       gmode,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             push_i,
  input  logic [MSG_W-1:0] push_data,
  input  logic             pop_i,
  output logic [MSG_W-1:0] pop_data,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             ovf_o,
  output logic             irq_o
);

  ctrl_t            ctrl;
  logic             depth_chg;
  logic [CNT_W-1:0] depth_n;
  logic [CNT_W-1:0] cnt_nxt;
  logic             push_ok;
  logic             flush;

  mrq_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .gmode    (gmode),
    .we       (reg_we),
    .w_thr    (reg_wdata[15:13]),
    .w_src    (reg_wdata[12]),
    .w_depth  (reg_wdata[10:8]),
    .w_irq_on (reg_wdata[1]),
    .w_on     (reg_wdata[0]),
    .ctrl     (ctrl),
    .depth_chg(depth_chg)
  );

  assign reg_rdata = {ctrl.thr, ctrl.src, 1'b0, ctrl.depth, 6'b0, ctrl.irq_on, ctrl.on};

  always_comb begin
    case (ctrl.depth)
      3'd1:    depth_n = CNT_W'(BASE_DEPTH);
      3'd2:    depth_n = CNT_W'(BASE_DEPTH * 2);
      3'd3:    depth_n = CNT_W'(MAX_DEPTH);
      default: depth_n = '0;
    endcase
  end

  assign flush = !ctrl.on || depth_chg;

  mrq_store #(
    .MSG_W    (MSG_W),
    .MAX_DEPTH(MAX_DEPTH),
    .PTR_W    (PTR_W),
    .CNT_W    (CNT_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .depth_n(depth_n),
    .push   (push_i),
    .wdat   (push_data),
    .pop    (pop_i),
    .rdat   (pop_data),
    .cnt    (fill_o),
    .cnt_nxt(cnt_nxt),
    .push_ok(push_ok),
    .empty  (empty_o),
    .full   (full_o),
    .ovf    (ovf_o)
  );

  mrq_irq #(.CNT_W(CNT_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .irq_on (ctrl.irq_on),
    .src    (ctrl.src),
    .thr    (ctrl.thr),
    .depth_n(depth_n),
    .push_ok(push_ok),
    .cnt_nxt(cnt_nxt),
    .irq    (irq_o)
  );

endmodule

// File: rtl/msg_rx_queue_chk.sv
module msg_rx_queue_chk #(
  parameter int CNT_W     = 5,
  parameter int MAX_DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       gmode,
  input logic             reg_we,
  input logic             push_i,
  input logic             pop_i,
  input logic             on,
  input logic             irq_on,
  input logic [4:0]       cfg,
  input logic             empty_o,
  input logic             full_o,
  input logic [CNT_W-1:0] fill_o,
  input logic             ovf_o,
  input logic             irq_o
);

  // R4
  cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && gmode != 2'b00) |=> (cfg == $past(cfg)));

  // R4
  on_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && (gmode == 2'b00 || gmode == 2'b11)) |=> (on == $past(on)));

  // R2
  irq_on_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && on) |=> (irq_on == $past(irq_on)));

  // R1
  off_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !on |=> (empty_o && fill_o == '0 && !ovf_o));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i && !pop_i && on && !$past(reg_we)) |=> (fill_o == $past(fill_o) && ovf_o));

  // R5
  flag_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (empty_o == (fill_o == '0)) && !(empty_o && full_o));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_o <= CNT_W'(MAX_DEPTH));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(push_i && on && irq_on));

endmodule

bind msg_rx_queue msg_rx_queue_chk #(.CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .gmode  (gmode),
  .reg_we (reg_we),
  .push_i (push_i),
  .pop_i  (pop_i),
  .on     (reg_rdata[0]),
  .irq_on (reg_rdata[1]),
  .cfg    (reg_rdata[12:8]),
  .empty_o(empty_o),
  .full_o (full_o),
  .fill_o (fill_o),
  .ovf_o  (ovf_o),
  .irq_o  (irq_o)
);

// File: tb/tb_msg_rx_queue.sv
module tb_msg_rx_queue;

  localparam int MSG_W = 32;
  localparam int CNT_W = 5;
  localparam logic [1:0] M_RST = 2'b00, M_OP = 2'b01, M_TST = 2'b10, M_NONE = 2'b11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       gmode = M_RST;
  logic             reg_we = 1'b0;
  logic [15:0]      reg_wdata = '0;
  logic [15:0]      reg_rdata;
  logic             push_i = 1'b0;
  logic [MSG_W-1:0] push_data = '0;
  logic             pop_i = 1'b0;
  logic [MSG_W-1:0] pop_data;
  logic             empty_o, full_o, ovf_o, irq_o;
  logic [CNT_W-1:0] fill_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  msg_rx_queue dut (
    .clk(clk), .rst(rst), .gmode(gmode), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .push_i(push_i), .push_data(push_data), .pop_i(pop_i),
    .pop_data(pop_data), .empty_o(empty_o), .full_o(full_o), .fill_o(fill_o),
    .ovf_o(ovf_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cword(input int d, input bit src, input int thr, input bit ie, input bit en);
    return {3'(thr), src, 1'b0, 3'(d), 6'b0, ie, en};
  endfunction

  function automatic int dep(input int code);
    return (code == 0) ? 0 : (4 << (code - 1));
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] m, input logic [15:0] d);
    @(negedge clk);
    gmode = m; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic push1(input logic [31:0] d, output bit irq);
    @(negedge clk);
    push_i = 1'b1; push_data = d;
    @(posedge clk); #1;
    irq = irq_o;
    push_i = 1'b0;
  endtask

  task automatic pop1(output logic [31:0] d);
    @(negedge clk);
    pop_i = 1'b1;
    @(posedge clk); #1;
    pop_i = 1'b0;
    d = pop_data;
  endtask

  task automatic cfg(input int d, input bit src, input int thr, input bit ie);
    wr(M_OP, 16'h0000);
    wr(M_RST, cword(d, src, thr, ie, 1'b0));
    wr(M_OP, cword(d, src, thr, ie, 1'b1));
    idle(1);
  endtask

  task automatic t_reset();
    chk("R11", "ctrl after reset", 32'(reg_rdata), 32'h0);
    chk("R11", "empty after reset", 32'(empty_o), 1);
    chk("R11", "full after reset", 32'(full_o), 0);
    chk("R11", "fill after reset", 32'(fill_o), 0);
    chk("R11", "ovf/irq after reset", {30'b0, ovf_o, irq_o}, 0);
    chk("R11", "pop_data after reset", pop_data, 0);
  endtask

  task automatic t_reg_rules();
    wr(M_RST, 16'hFFFF);
    chk("R4", "on ignored in reset mode, bad depth kept", 32'(reg_rdata), 32'hF002);
    chk("R3", "prohibited depth code ignored", 32'(reg_rdata[10:8]), 0);
    wr(M_RST, cword(2, 0, 3, 1, 0));
    chk("R3", "depth code 010 accepted", 32'(reg_rdata), 32'h6202);
    wr(M_OP, cword(3, 1, 3, 1, 1));
    chk("R4", "depth/src ignored in operating mode", 32'(reg_rdata), 32'h6203);
    wr(M_OP, cword(2, 0, 3, 0, 1));
    chk("R2", "irq_on change ignored while on", 32'(reg_rdata), 32'h6203);
    wr(M_NONE, cword(2, 0, 3, 1, 0));
    chk("R4", "on ignored in mode 11", 32'(reg_rdata), 32'h6203);
    wr(M_TST, cword(2, 0, 5, 1, 0));
    chk("R4", "on cleared in test mode, thr written", 32'(reg_rdata), 32'hA202);
    wr(M_TST, cword(2, 0, 5, 1, 1));
    chk("R1", "on set in test mode", 32'(reg_rdata[0]), 1);
    wr(M_OP, 16'h0000);
    idle(1);
  endtask

  task automatic t_depth(input int code);
    int d;
    bit irq;
    logic [31:0] got;
    logic [31:0] q[$];
    d = dep(code);
    cfg(code, 1'b0, 7, 1'b0);
    for (int i = 0; i < d; i++) begin
      q.push_back(32'(code * 256 + i + 1));
      push1(32'(code * 256 + i + 1), irq);
      chk("R5", "fill while filling", 32'(fill_o), 32'(i + 1));
    end
    chk("R5", "full at depth", 32'(full_o), 1);
    chk("R5", "not empty when full", 32'(empty_o), 0);
    push1(32'hDEAD, irq);
    chk("R8", "fill unchanged on overflow", 32'(fill_o), 32'(d));
    chk("R8", "ovf set", 32'(ovf_o), 1);
    for (int i = 0; i < d; i++) begin
      pop1(got);
      chk("R5", "pop order", got, q.pop_front());
    end
    chk("R5", "empty after drain", 32'(empty_o), 1);
    chk("R8", "ovf sticky after drain", 32'(ovf_o), 1);
    pop1(got);
    chk("R9", "pop on empty keeps data", got, 32'(code * 256 + d));
    chk("R9", "pop on empty keeps fill", 32'(fill_o), 0);
    wr(M_OP, 16'h0000);
    idle(1);
    chk("R8", "ovf cleared by switching off", 32'(ovf_o), 0);
  endtask

  task automatic t_thresh(input int code, input int thr);
    int d, expn, hits, at;
    bit irq;
    d = dep(code);
    expn = (d * (thr + 1) + 7) / 8;
    if (expn < 1) expn = 1;
    hits = 0; at = 0;
    cfg(code, 1'b0, thr, 1'b1);
    for (int i = 0; i < d; i++) begin
      push1(32'(i), irq);
      if (irq) begin
        hits++;
        at = i + 1;
      end
    end
    chk("R7", $sformatf("pulse count depth %0d code %0d", d, thr), 32'(hits), 1);
    chk("R7", $sformatf("pulse fill depth %0d code %0d", d, thr), 32'(at), 32'(expn));
  endtask

  task automatic t_per_msg();
    bit irq;
    int hits;
    cfg(2, 1'b1, 0, 1'b1);
    hits = 0;
    for (int i = 0; i < 5; i++) begin
      push1(32'(i), irq);
      hits += int'(irq);
    end
    chk("R6", "pulse on every message", 32'(hits), 5);
    cfg(2, 1'b1, 0, 1'b0);
    hits = 0;
    for (int i = 0; i < 3; i++) begin
      push1(32'(i), irq);
      hits += int'(irq);
    end
    chk("R2", "no pulse with irq_on clear", 32'(hits), 0);
    chk("R2", "pushes still stored", 32'(fill_o), 3);
  endtask

  task automatic t_discard();
    bit irq;
    int hits;
    cfg(2, 1'b1, 0, 1'b1);
    for (int i = 0; i < 3; i++) push1(32'(i), irq);
    chk("R1", "fill before switch off", 32'(fill_o), 3);
    wr(M_OP, cword(2, 1, 0, 1, 0));
    idle(1);
    chk("R1", "empty after switch off", 32'(empty_o), 1);
    chk("R1", "fill zero after switch off", 32'(fill_o), 0);
    hits = 0;
    for (int i = 0; i < 2; i++) begin
      push1(32'(i), irq);
      hits += int'(irq);
    end
    chk("R10", "pushes dropped while off", 32'(fill_o), 0);
    chk("R10", "no pulse while off", 32'(hits), 0);
    cfg(0, 1'b1, 0, 1'b1);
    hits = 0;
    for (int i = 0; i < 2; i++) begin
      push1(32'(i), irq);
      hits += int'(irq);
    end
    chk("R10", "pushes dropped with depth 000", 32'(fill_o), 0);
    chk("R10", "empty with depth 000", 32'(empty_o), 1);
    chk("R10", "no pulse with depth 000", 32'(hits), 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_reg_rules();
    for (int c = 1; c <= 3; c++) t_depth(c);
    for (int c = 1; c <= 3; c++) begin
      for (int t = 0; t < 8; t++) t_thresh(c, t);
    end
    t_per_msg();
    t_discard();
    report();
    $finish;
  end

endmodule